// File: doc/BRIEF.md
# Host-Side Slave Register Interface

This block sits between an 8-bit master bus and the core of a slave peripheral controller. The master sees a small port with an active-low chip select, active-low read and write strobes, and one address bit. That bit tags every transfer as either data or command. The master writes bytes into an inbound buffer and reads bytes from an outbound buffer. It can also read an 8-bit status byte that reports the buffer state, two flags and four bits owned by the local core.

The local core sees the other side of the block:
- a strobe that consumes the inbound byte;
- a load strobe with a data byte for the outbound buffer;
- a write port for the upper status nibble;
- set, clear and complement strobes for a general-purpose flag.

The host strobes arrive asynchronously. They pass through a synchroniser, and all flag changes happen on the trailing edge of the synchronised strobe. While the host is reading status, the status byte it sees is frozen. Local changes made during that read become visible to the host once the read ends.

Top module: `hif_regs`

## Requirements
- R1: After reset, the status byte, the inbound buffer and the outbound buffer all read as zero.
- R2: The status byte is laid out as bits 7:4 user nibble, bit 3 F1, bit 2 F0, bit 1 IBF (inbound full), bit 0 OBF (outbound full). A host read with address bit 1 returns this byte and changes no flag.
- R3: A selected host write stores the byte in the inbound buffer and sets IBF. It clears F1 when the address bit is 0 and sets F1 when the address bit is 1.
- R4: IBF, OBF and F1 do not change while a host strobe is held active. They change only after the strobe's trailing (deasserting) edge has passed the synchroniser.
- R5: A local inbound-read strobe clears IBF and leaves the inbound byte unchanged.
- R6: A local load stores a byte in the outbound buffer and sets OBF. A selected host read with address bit 0 returns that byte and clears OBF after the trailing edge.
- R7: With chip select inactive (high), host strobes change no buffer and no flag.
- R8: A local status write copies its 4-bit input into status bits 7:4 and leaves bits 3:0 unchanged.
- R9: F0 is set by the local set strobe, cleared by the clear strobe and toggled by the complement strobe. Clear beats set, and complement acts only when neither set nor clear is present.
- R10: While a selected host status read is in progress, the status byte on the host data output holds its value. Local updates made during the read show on the local status output at once and reach the host view after the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_ni | input | 1 | Host chip select, active low |
| host_rd_ni | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_ni | input | 1 | Host write strobe, active low, asynchronous |
| host_a0_i | input | 1 | Address bit: 0 data, 1 command/status |
| host_d_i | input | 8 | Host write data |
| host_d_o | output | 8 | Host read data: status view when address bit is 1, outbound buffer otherwise |
| ibuf_rd_i | input | 1 | Local strobe that consumes the inbound byte |
| ibuf_q_o | output | 8 | Inbound buffer contents |
| obuf_ld_i | input | 1 | Local strobe that loads the outbound buffer |
| obuf_d_i | input | 8 | Outbound load data |
| sts_wr_i | input | 1 | Local strobe that writes the user status nibble |
| sts_user_i | input | 4 | Upper accumulator nibble written to status bits 7:4 |
| f0_set_i | input | 1 | Set F0 |
| f0_clr_i | input | 1 | Clear F0 |
| f0_cpl_i | input | 1 | Toggle F0 |
| status_o | output | 8 | Live status byte for the local core |
| ibf_o | output | 1 | Inbound buffer full |
| obf_o | output | 1 | Outbound buffer full |
| f1_o | output | 1 | Command/data tag of the last host write |

## Verification
The assertions rely on the host holding chip select, the address bit and the write data steady from before a strobe's leading edge until several clocks after its trailing edge. They also rely on each strobe staying active, and then inactive, for more than the synchroniser depth. With these conditions, the values latched at the synchronised leading edge are the ones committed at the trailing edge.

The stimulus keeps to these conditions: every host task settles select, address and data one clock before lowering a strobe. It holds the strobe for several clocks and keeps the address and select in place for six clocks after release. Local strobes are single-cycle pulses, issued away from host commits, so the set-over-clear ordering between the two sides is never relied on.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int DATA_W = 8;
  localparam int USER_W = 4;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [USER_W-1:0] user;
    logic              f1;
    logic              f0;
    logic              ibf;
    logic              obf;
  } hif_status_t;
endpackage

// File: rtl/hif_strobe_sync.sv
module hif_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic act_o,
  output logic lead_o,
  output logic trail_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], ~strobe_ni};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign act_o   = chain_q[STAGES-1];
  assign lead_o  = chain_q[STAGES-1] & ~prev_q;
  assign trail_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/hif_dbb.sv
module hif_dbb
  import hif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] host_d_i,
  input  logic              wr_lead_i,
  input  logic              wr_trail_i,
  input  logic              rd_act_i,
  input  logic              rd_lead_i,
  input  logic              rd_trail_i,
  input  logic              ibuf_rd_i,
  input  logic              obuf_ld_i,
  input  logic [DATA_W-1:0] obuf_d_i,
  output logic [DATA_W-1:0] ibuf_q_o,
  output logic [DATA_W-1:0] obuf_q_o,
  output logic              ibf_o,
  output logic              obf_o,
  output logic              f1_o,
  output logic              lock_o
);
  logic              wcs_q, wa0_q, rcs_q, ra0_q;
  logic [DATA_W-1:0] wd_q, ibuf_q, obuf_q;
  logic              ibf_q, obf_q, f1_q;
  logic              wr_commit, rd_data_commit;

  // select, tag and data are latched when the synchronised strobe starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcs_q <= 1'b0;
      wa0_q <= 1'b0;
      wd_q  <= '0;
      rcs_q <= 1'b0;
      ra0_q <= 1'b0;
    end else begin
      if (wr_lead_i) begin
        wcs_q <= cs_i;
        wa0_q <= a0_i;
        wd_q  <= host_d_i;
      end
      if (rd_lead_i) begin
        rcs_q <= cs_i;
        ra0_q <= a0_i;
      end
    end
  end

  assign wr_commit      = wr_trail_i & wcs_q;
  assign rd_data_commit = rd_trail_i & rcs_q & ~ra0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibuf_q <= '0;
      obuf_q <= '0;
      ibf_q  <= 1'b0;
      obf_q  <= 1'b0;
      f1_q   <= 1'b0;
    end else begin
      if (wr_commit) begin
        ibuf_q <= wd_q;
        f1_q   <= wa0_q;
        ibf_q  <= 1'b1;
      end else if (ibuf_rd_i) begin
        ibf_q  <= 1'b0;
      end
      if (obuf_ld_i) begin
        obuf_q <= obuf_d_i;
        obf_q  <= 1'b1;
      end else if (rd_data_commit) begin
        obf_q  <= 1'b0;
      end
    end
  end

  assign ibuf_q_o = ibuf_q;
  assign obuf_q_o = obuf_q;
  assign ibf_o    = ibf_q;
  assign obf_o    = obf_q;
  assign f1_o     = f1_q;
  assign lock_o   = rd_act_i & ~rd_lead_i & rcs_q & ra0_q;

  // R4
  ibf_rise_on_trail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_q) |-> $past(wr_trail_i));
  // R5
  ibf_fall_on_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ibf_q) |-> $past(ibuf_rd_i));
  // R6
  obf_rise_on_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(obf_q) |-> $past(obuf_ld_i));
  // R7
  f1_needs_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(f1_q) |-> $past(wcs_q && wr_trail_i));
  // R6
  obf_fall_on_trail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(obf_q) |-> $past(rd_trail_i));
endmodule

// File: rtl/hif_status.sv
module hif_status
  import hif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sts_wr_i,
  input  logic [USER_W-1:0] sts_user_i,
  input  logic              f0_set_i,
  input  logic              f0_clr_i,
  input  logic              f0_cpl_i,
  input  logic              f1_i,
  input  logic              ibf_i,
  input  logic              obf_i,
  input  logic              lock_i,
  output hif_status_t       live_o,
  output hif_status_t       view_o
);
  logic [USER_W-1:0] user_q;
  logic              f0_q;
  hif_status_t       live, view_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q <= '0;
      f0_q   <= 1'b0;
    end else begin
      if (sts_wr_i) user_q <= sts_user_i;
      if (f0_clr_i)      f0_q <= 1'b0;
      else if (f0_set_i) f0_q <= 1'b1;
      else if (f0_cpl_i) f0_q <= ~f0_q;
    end
  end

  always_comb begin
    live.user = user_q;
    live.f1   = f1_i;
    live.f0   = f0_q;
    live.ibf  = ibf_i;
    live.obf  = obf_i;
  end

  // host view tracks live status except while the host is reading it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      view_q <= '0;
    else if (!lock_i) view_q <= live;
  end

  assign live_o = live;
  assign view_o = view_q;

  // R10
  view_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && $past(lock_i)) |-> $stable(view_q));
  // R9
  f0_clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f0_clr_i |=> !live_o.f0);
  // R8
  user_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_i |=> (live_o.user == $past(sts_user_i)));
endmodule

// File: rtl/hif_regs.sv
module hif_regs
  import hif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_ni,
  input  logic              host_rd_ni,
  input  logic              host_wr_ni,
  input  logic              host_a0_i,
  input  logic [DATA_W-1:0] host_d_i,
  output logic [DATA_W-1:0] host_d_o,
  input  logic              ibuf_rd_i,
  output logic [DATA_W-1:0] ibuf_q_o,
  input  logic              obuf_ld_i,
  input  logic [DATA_W-1:0] obuf_d_i,
  input  logic              sts_wr_i,
  input  logic [USER_W-1:0] sts_user_i,
  input  logic              f0_set_i,
  input  logic              f0_clr_i,
  input  logic              f0_cpl_i,
  output logic [DATA_W-1:0] status_o,
  output logic              ibf_o,
  output logic              obf_o,
  output logic              f1_o
);
  logic              wr_act, wr_lead, wr_trail;
  logic              rd_act, rd_lead, rd_trail;
  logic              lock, ibf, obf, f1;
  logic [DATA_W-1:0] obuf_q;
  hif_status_t       live, view;

  hif_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i, .rst_ni, .strobe_ni(host_wr_ni),
    .act_o(wr_act), .lead_o(wr_lead), .trail_o(wr_trail));

  hif_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk_i, .rst_ni, .strobe_ni(host_rd_ni),
    .act_o(rd_act), .lead_o(rd_lead), .trail_o(rd_trail));

  hif_dbb u_dbb (
    .clk_i, .rst_ni,
    .cs_i(~host_cs_ni), .a0_i(host_a0_i), .host_d_i,
    .wr_lead_i(wr_lead), .wr_trail_i(wr_trail),
    .rd_act_i(rd_act), .rd_lead_i(rd_lead), .rd_trail_i(rd_trail),
    .ibuf_rd_i, .obuf_ld_i, .obuf_d_i,
    .ibuf_q_o, .obuf_q_o(obuf_q),
    .ibf_o(ibf), .obf_o(obf), .f1_o(f1), .lock_o(lock));

  hif_status u_status (
    .clk_i, .rst_ni, .sts_wr_i, .sts_user_i,
    .f0_set_i, .f0_clr_i, .f0_cpl_i,
    .f1_i(f1), .ibf_i(ibf), .obf_i(obf), .lock_i(lock),
    .live_o(live), .view_o(view));

  assign host_d_o = host_a0_i ? view : obuf_q;
  assign status_o = live;
  assign ibf_o    = ibf;
  assign obf_o    = obf;
  assign f1_o     = f1;

  // R4
  wr_strobe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && $past(wr_act)) |=> $stable(ibf_o) || $past(ibuf_rd_i));
endmodule

// File: tb/hif_regs_bench.sv
module hif_regs_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_cs_ni = 1'b1, host_rd_ni = 1'b1, host_wr_ni = 1'b1, host_a0_i = 1'b0;
  logic [7:0] host_d_i = '0, obuf_d_i = '0;
  logic [3:0] sts_user_i = '0;
  logic       ibuf_rd_i = 0, obuf_ld_i = 0, sts_wr_i = 0;
  logic       f0_set_i = 0, f0_clr_i = 0, f0_cpl_i = 0;
  logic [7:0] host_d_o, ibuf_q_o, status_o;
  logic       ibf_o, obf_o, f1_o;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] rdv;

  always #2 clk = ~clk;

  hif_regs u_hif_regs (
    .clk_i(clk), .rst_ni, .host_cs_ni, .host_rd_ni, .host_wr_ni, .host_a0_i,
    .host_d_i, .host_d_o, .ibuf_rd_i, .ibuf_q_o, .obuf_ld_i, .obuf_d_i,
    .sts_wr_i, .sts_user_i, .f0_set_i, .f0_clr_i, .f0_cpl_i,
    .status_o, .ibf_o, .obf_o, .f1_o);

  // kind: 0 host write, 1 host read, 2 outbound load, 3 inbound consume, 4 user status write
  // {kind[2:0], a0, data[7:0], exp_status[7:0], exp_aux[7:0]}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {3'd0, 1'b0, 8'hA5, 8'h02, 8'hA5},
    {3'd3, 1'b0, 8'h00, 8'h00, 8'hA5},
    {3'd0, 1'b1, 8'h3C, 8'h0A, 8'h3C},
    {3'd3, 1'b0, 8'h00, 8'h08, 8'h3C},
    {3'd4, 1'b0, 8'h5F, 8'h58, 8'h3C},
    {3'd2, 1'b0, 8'h96, 8'h59, 8'h3C},
    {3'd1, 1'b1, 8'h00, 8'h59, 8'h59},
    {3'd1, 1'b0, 8'h00, 8'h58, 8'h96},
    {3'd0, 1'b0, 8'h11, 8'h52, 8'h11},
    {3'd4, 1'b0, 8'hA0, 8'hA2, 8'h11},
    {3'd3, 1'b0, 8'h00, 8'hA0, 8'h11}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic cs_n, input logic a0, input logic [7:0] d, input int hold);
    @(negedge clk);
    host_cs_ni = cs_n; host_a0_i = a0; host_d_i = d;
    @(negedge clk);
    host_wr_ni = 1'b0;
    repeat (hold) @(negedge clk);
    host_wr_ni = 1'b1;
    repeat (6) @(negedge clk);
    host_cs_ni = 1'b1;
  endtask

  task automatic host_read(input logic cs_n, input logic a0, output logic [7:0] d);
    @(negedge clk);
    host_cs_ni = cs_n; host_a0_i = a0;
    @(negedge clk);
    host_rd_ni = 1'b0;
    repeat (4) @(negedge clk);
    d = host_d_o;
    host_rd_ni = 1'b1;
    repeat (6) @(negedge clk);
    host_cs_ni = 1'b1;
  endtask

  task automatic pulse(input int which, input logic [7:0] d);
    @(negedge clk);
    case (which)
      2: begin obuf_d_i = d; obuf_ld_i = 1'b1; end
      3: ibuf_rd_i = 1'b1;
      4: begin sts_user_i = d[7:4]; sts_wr_i = 1'b1; end
      5: f0_set_i = 1'b1;
      6: f0_clr_i = 1'b1;
      7: f0_cpl_i = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    obuf_ld_i = 0; ibuf_rd_i = 0; sts_wr_i = 0;
    f0_set_i = 0; f0_clr_i = 0; f0_cpl_i = 0;
    repeat (2) @(negedge clk);
  endtask

  function automatic string kind_tag(input logic [2:0] k, input logic a0);
    case (k)
      3'd0: return "R3";
      3'd1: return a0 ? "R2" : "R6";
      3'd2: return "R6";
      3'd3: return "R5";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 status", status_o, 8'h00);
    check("R1 inbound", ibuf_q_o, 8'h00);
    host_a0_i = 1'b0; #1;
    check("R1 outbound", host_d_o, 8'h00);
    host_a0_i = 1'b1; #1;
    check("R1 host status", host_d_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] k;
      logic       a;
      logic [7:0] d, es, ea;
      {k, a, d, es, ea} = VEC[i];
      case (k)
        3'd0: host_write(1'b0, a, d, 4);
        3'd1: host_read(1'b0, a, rdv);
        default: pulse(int'(k), d);
      endcase
      check({kind_tag(k, a), " status"}, status_o, es);
      if (k == 3'd1) check({kind_tag(k, a), " read data"}, rdv, ea);
      else           check({kind_tag(k, a), " inbound"}, ibuf_q_o, ea);
    end

    // R4 flags stay put while strobe is held
    @(negedge clk);
    host_cs_ni = 1'b0; host_a0_i = 1'b1; host_d_i = 8'h77;
    @(negedge clk);
    host_wr_ni = 1'b0;
    repeat (8) @(negedge clk);
    check("R4 ibf during strobe", {7'd0, ibf_o}, 8'h00);
    check("R4 f1 during strobe", {7'd0, f1_o}, 8'h00);
    host_wr_ni = 1'b1;
    repeat (6) @(negedge clk);
    host_cs_ni = 1'b1;
    check("R4 after trailing edge", status_o, 8'hAA);
    check("R3 command byte", ibuf_q_o, 8'h77);
    pulse(3, 8'h00);

    // R7 deselected transfers do nothing
    host_write(1'b1, 1'b0, 8'h55, 4);
    check("R7 write ignored status", status_o, 8'hA8);
    check("R7 write ignored data", ibuf_q_o, 8'h77);
    pulse(2, 8'h33);
    host_read(1'b1, 1'b0, rdv);
    check("R7 read ignored", status_o, 8'hA9);
    host_read(1'b0, 1'b0, rdv);
    check("R6 second read data", rdv, 8'h33);
    check("R6 obf cleared", status_o, 8'hA8);

    // R9 F0 controls
    pulse(5, 8'h00);
    check("R9 set", status_o, 8'hAC);
    pulse(7, 8'h00);
    check("R9 complement low", status_o, 8'hA8);
    pulse(7, 8'h00);
    check("R9 complement high", status_o, 8'hAC);
    @(negedge clk);
    f0_set_i = 1'b1; f0_clr_i = 1'b1; f0_cpl_i = 1'b1;
    @(negedge clk);
    f0_set_i = 1'b0; f0_clr_i = 1'b0; f0_cpl_i = 1'b0;
    @(negedge clk);
    check("R9 clear wins", status_o, 8'hA8);

    // R10 status lockout
    @(negedge clk);
    host_cs_ni = 1'b0; host_a0_i = 1'b1;
    @(negedge clk);
    host_rd_ni = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 view before update", host_d_o, 8'hA8);
    pulse(4, 8'hF0);
    pulse(5, 8'h00);
    check("R10 view frozen", host_d_o, 8'hA8);
    check("R10 live updated", status_o, 8'hFC);
    host_rd_ni = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 view after read", host_d_o, 8'hFC);
    host_cs_ni = 1'b1;

    // R1 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 status after reset", status_o, 8'h00);
    check("R1 inbound after reset", ibuf_q_o, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule